// File: doc/BRIEF.md
# Serial Register Control Port

This block is a four-wire serial control slave. A host frames each command with an active-low latch and clocks in a 24-bit word, most significant bit first. The first byte holds a seven-bit chip identifier and a read/write flag. The second byte picks a register, and the third byte carries the data. Writes update a small register file whose contents leave the block as one flat configuration vector. On a read, the block drives the addressed register back on a serial output while the third byte is being clocked.

The serial pins may run with no phase relation to the system clock. The block synchronizes them into its own clock domain and detects their edges there. While reset is held, a strap check samples the three input pins. If all three are low, the port enters a fallback mode with no serial control: commands are ignored and the registers keep their defaults, except that the internal master-clock enable bit is forced on.

Top module: `spi_ctl_port`

## Requirements
- R1: While `latch_n` is low, one data bit is taken from `sdi` on each rising edge of `sclk`, most significant bit first, into a 24-bit command word.
- R2: A command acts only when bits 23:17 of the word equal the chip identifier 0x04. Any other identifier leaves the registers unchanged and keeps `sdo_oe` low.
- R3: Bit 16 of the word selects the access (0 = write, 1 = read). Bits 15:8 hold the register address and bits 7:0 the write data. Wire byte 0x08 therefore writes and byte 0x09 reads.
- R4: A write takes effect on the rising edge of `latch_n` only if exactly 24 `sclk` rising edges were seen while the latch was low. With 23 or 25 edges, nothing changes.
- R5: During a valid read, `sdo_oe` is high for the eight bits of the third byte, and `sdo` presents the addressed register MSB first. Each bit changes after a falling `sclk` edge, so the host samples it on the next rising edge.
- R6: `sdo_oe` is low whenever `latch_n` is high (after the synchronizer delay).
- R7: A write to an address at or above the register count (8) has no effect, and a read from such an address returns 0x00.
- R8: Reset with the strap not active returns every register to its default of 0x00 and leaves `standalone` low.
- R9: If `sclk`, `sdi` and `latch_n` are all low while `rst` is held, `standalone` goes high. From then on every serial command is ignored and `sdo_oe` stays low.
- R10: In standalone mode every register holds its default, except bit 0 of register 0 (the master-clock enable), which reads 1.
- R11: The serial pins are asynchronous to `clk`. Correct operation needs each `sclk` high and low phase to last at least four `clk` cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset; strap is sampled while high |
| sclk | input | 1 | Serial clock from host |
| sdi | input | 1 | Serial data from host |
| latch_n | input | 1 | Active-low frame latch |
| sdo | output | 1 | Serial read data |
| sdo_oe | output | 1 | Output enable for `sdo` (low = tri-state) |
| standalone | output | 1 | High when the fallback strap was seen at reset |
| cfg_flat | output | 64 | All registers, register i at bits [8*i+7:8*i] |

## Verification
The bench aims at frame-length errors: a 23-bit or 25-bit frame must not commit. A design that counts loosely would let such a frame corrupt a register, and the flat configuration output would show it. Foreign chip identifiers and out-of-range addresses are mixed into the random traffic, because a decoder that skips the identifier or wraps the address would write or answer where it must stay silent. Read-back checks both the bit order and the one-edge offset of `sdo`; an off-by-one in the load point would return shifted data. The strap is tested by resetting with all pins low and then sending writes and reads: a leaky fallback would change registers, enable `sdo`, or fail to force the master-clock enable bit.

// File: rtl/spi_ctl_pkg.sv
package spi_ctl_pkg;
  localparam int FRAME_BITS = 24;
  localparam int BYTE_W     = 8;
  localparam logic [6:0] CHIP_ID = 7'h04;
  localparam int CNT_W      = 6;
endpackage

// File: rtl/spi_sync.sv
module spi_sync #(
  parameter int W = 3
) (
  input  logic         clk,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    logic s1, s2;
    always_ff @(posedge clk) begin
      s1 <= d[i];
      s2 <= s1;
    end
    assign q[i] = s2;
  end
endmodule

// File: rtl/spi_frame.sv
module spi_frame
  import spi_ctl_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              standalone,
  input  logic              sclk_s,
  input  logic              sdi_s,
  input  logic              lat_s,
  input  logic [BYTE_W-1:0] rd_data,
  output logic [BYTE_W-1:0] rd_addr,
  output logic              wr_en,
  output logic [BYTE_W-1:0] wr_addr,
  output logic [BYTE_W-1:0] wr_data,
  output logic              sdo,
  output logic              sdo_oe
);
  localparam logic [CNT_W-1:0] CNT_MAX  = '1;
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(FRAME_BITS);
  localparam logic [CNT_W-1:0] CNT_HDR  = CNT_W'(2 * BYTE_W);

  logic                  sclk_q, lat_q;
  logic [FRAME_BITS-1:0] sr;
  logic [CNT_W-1:0]      cnt;
  logic [BYTE_W-1:0]     out_sr;
  logic                  rise, fall, lat_rise, rd_go;

  assign rise     = sclk_s & ~sclk_q;
  assign fall     = ~sclk_s & sclk_q;
  assign lat_rise = lat_s & ~lat_q;
  assign rd_addr  = sr[BYTE_W-1:0];
  assign rd_go    = (sr[2*BYTE_W-1 -: 7] == CHIP_ID) && sr[BYTE_W] && !standalone;
  assign sdo      = out_sr[BYTE_W-1];

  always_ff @(posedge clk) begin
    if (rst) begin
      sclk_q  <= 1'b0;
      lat_q   <= 1'b1;
      sr      <= '0;
      cnt     <= '0;
      wr_en   <= 1'b0;
      wr_addr <= '0;
      wr_data <= '0;
      out_sr  <= '0;
      sdo_oe  <= 1'b0;
    end else begin
      sclk_q <= sclk_s;
      lat_q  <= lat_s;
      wr_en  <= 1'b0;
      if (lat_rise) begin
        wr_en   <= (cnt == CNT_FULL) && (sr[FRAME_BITS-1 -: 7] == CHIP_ID)
                   && !sr[2*BYTE_W] && !standalone;
        wr_addr <= sr[2*BYTE_W-1 -: BYTE_W];
        wr_data <= sr[BYTE_W-1:0];
      end
      if (lat_s) begin
        cnt    <= '0;
        sdo_oe <= 1'b0;
      end else begin
        if (rise) begin
          sr <= {sr[FRAME_BITS-2:0], sdi_s};
          if (cnt != CNT_MAX) cnt <= cnt + 1'b1;
        end
        if (fall) begin
          if (cnt == CNT_HDR) begin
            out_sr <= rd_data;
            sdo_oe <= rd_go;
          end else if (cnt > CNT_HDR && cnt < CNT_FULL) begin
            out_sr <= {out_sr[BYTE_W-2:0], 1'b0};
          end else if (cnt >= CNT_FULL) begin
            sdo_oe <= 1'b0;
          end
        end
      end
    end
  end
endmodule

// File: rtl/spi_regfile.sv
module spi_regfile
  import spi_ctl_pkg::*;
#(
  parameter int          NREGS    = 8,
  parameter int          MCLK_BIT = 0,
  parameter logic [7:0]  DEF_VAL  = 8'h00
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    standalone,
  input  logic                    wr_en,
  input  logic [BYTE_W-1:0]       wr_addr,
  input  logic [BYTE_W-1:0]       wr_data,
  input  logic [BYTE_W-1:0]       rd_addr,
  output logic [BYTE_W-1:0]       rd_data,
  output logic [NREGS*BYTE_W-1:0] cfg_flat
);
  localparam int IDXW = (NREGS > 1) ? $clog2(NREGS) : 1;
  localparam logic [BYTE_W-1:0] NREGS_A = BYTE_W'(NREGS);

  logic [BYTE_W-1:0] regs [NREGS];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NREGS; i++) regs[i] <= DEF_VAL;
    end else if (standalone) begin
      for (int i = 0; i < NREGS; i++) regs[i] <= DEF_VAL;
      regs[0][MCLK_BIT] <= 1'b1;
    end else if (wr_en && (wr_addr < NREGS_A)) begin
      regs[wr_addr[IDXW-1:0]] <= wr_data;
    end
  end

  assign rd_data = (rd_addr < NREGS_A) ? regs[rd_addr[IDXW-1:0]] : '0;

  for (genvar i = 0; i < NREGS; i++) begin : g_flat
    assign cfg_flat[i*BYTE_W +: BYTE_W] = regs[i];
  end
endmodule

// File: rtl/spi_ctl_port.sv
module spi_ctl_port
  import spi_ctl_pkg::*;
#(
  parameter int NREGS    = 8,
  parameter int MCLK_BIT = 0
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    sclk,
  input  logic                    sdi,
  input  logic                    latch_n,
  output logic                    sdo,
  output logic                    sdo_oe,
  output logic                    standalone,
  output logic [NREGS*BYTE_W-1:0] cfg_flat
);
  logic [2:0]        pins_s;
  logic              sclk_s, sdi_s, lat_s;
  logic              wr_en;
  logic [BYTE_W-1:0] wr_addr, wr_data, rd_addr, rd_data;

  spi_sync #(.W(3)) u_sync (
    .clk (clk),
    .d   ({sclk, sdi, latch_n}),
    .q   (pins_s)
  );
  assign {sclk_s, sdi_s, lat_s} = pins_s;

  always_ff @(posedge clk) begin
    if (rst) standalone <= ~(sclk_s | sdi_s | lat_s);
  end

  spi_frame u_frame (
    .clk        (clk),
    .rst        (rst),
    .standalone (standalone),
    .sclk_s     (sclk_s),
    .sdi_s      (sdi_s),
    .lat_s      (lat_s),
    .rd_data    (rd_data),
    .rd_addr    (rd_addr),
    .wr_en      (wr_en),
    .wr_addr    (wr_addr),
    .wr_data    (wr_data),
    .sdo        (sdo),
    .sdo_oe     (sdo_oe)
  );

  spi_regfile #(.NREGS(NREGS), .MCLK_BIT(MCLK_BIT)) u_regs (
    .clk        (clk),
    .rst        (rst),
    .standalone (standalone),
    .wr_en      (wr_en),
    .wr_addr    (wr_addr),
    .wr_data    (wr_data),
    .rd_addr    (rd_addr),
    .rd_data    (rd_data),
    .cfg_flat   (cfg_flat)
  );
endmodule

// File: rtl/spi_ctl_port_chk.sv
module spi_ctl_port_chk #(
  parameter int NREGS    = 8,
  parameter int MCLK_BIT = 0
) (
  input logic                 clk,
  input logic                 rst,
  input logic                 standalone,
  input logic                 sdo_oe,
  input logic                 lat_s,
  input logic                 wr_en,
  input logic [NREGS*8-1:0]   cfg_flat
);
  p_oe_latch_low_r6: assert property (@(posedge clk) disable iff (rst)
    sdo_oe |-> !$past(lat_s));

  p_standalone_quiet_r9: assert property (@(posedge clk) disable iff (rst)
    standalone |-> !sdo_oe);

  p_standalone_nowrite_r9: assert property (@(posedge clk) disable iff (rst)
    standalone |-> !wr_en);

  p_mclk_forced_r10: assert property (@(posedge clk) disable iff (rst)
    standalone |=> cfg_flat[MCLK_BIT]);

  p_cfg_only_by_write_r4: assert property (@(posedge clk) disable iff (rst)
    (!standalone && !$past(wr_en)) |-> $stable(cfg_flat));
endmodule

bind spi_ctl_port spi_ctl_port_chk #(.NREGS(NREGS), .MCLK_BIT(MCLK_BIT)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .standalone (standalone),
  .sdo_oe     (sdo_oe),
  .lat_s      (lat_s),
  .wr_en      (wr_en),
  .cfg_flat   (cfg_flat)
);

// File: tb/spi_ctl_port_tb.sv
module spi_ctl_port_tb_top;
  localparam int NREGS = 8;
  localparam int HALF  = 6;

  logic clk = 1'b0;
  logic rst, sclk, sdi, latch_n;
  logic sdo, sdo_oe, standalone;
  logic [NREGS*8-1:0] cfg_flat;

  int checks = 0, failures = 0;
  bit done = 0;
  logic [7:0] model [NREGS];
  bit in_sa = 0;
  int hi_cnt = 0;

  always #2.5 clk = ~clk;

  spi_ctl_port #(.NREGS(NREGS)) dut_i (
    .clk(clk), .rst(rst), .sclk(sclk), .sdi(sdi), .latch_n(latch_n),
    .sdo(sdo), .sdo_oe(sdo_oe), .standalone(standalone), .cfg_flat(cfg_flat)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wt(input int n);
    repeat (n) @(negedge clk);
  endtask

  // R6 / R9 monitor: no drive while latch idle or in fallback mode
  always @(negedge clk) begin
    if (!rst) begin
      hi_cnt = latch_n ? hi_cnt + 1 : 0;
      if (sdo_oe && (hi_cnt > 5 || in_sa)) begin
        failures++;
        $display("FAIL R6/R9 sdo_oe actual=1 expected=0");
      end
    end
  end

  function automatic logic [63:0] exp_cfg();
    logic [63:0] v = '0;
    for (int i = 0; i < NREGS; i++) v[i*8 +: 8] = model[i];
    return v;
  endfunction

  task automatic xfer(input logic [23:0] w, input int nbits,
                      output logic [7:0] rd, output logic oe_all, output logic oe_any);
    rd = '0; oe_all = 1'b1; oe_any = 1'b0;
    latch_n = 1'b0;
    wt(HALF);
    for (int i = 0; i < nbits; i++) begin
      sclk = 1'b0;
      sdi  = (i < 24) ? w[23-i] : 1'b0;
      wt(HALF);
      if (i >= 16 && i < 24) begin
        rd = {rd[6:0], sdo};
        oe_all = oe_all & sdo_oe;
        oe_any = oe_any | sdo_oe;
      end
      sclk = 1'b1;
      wt(HALF);
    end
    sclk = 1'b0;
    wt(HALF);
    latch_n = 1'b1;
    sdi = 1'b1;
    wt(10);
  endtask

  task automatic do_reset(input bit strap);
    rst = 1'b1;
    sclk = 1'b0;
    sdi = strap ? 1'b0 : 1'b1;
    latch_n = strap ? 1'b0 : 1'b1;
    wt(8);
    rst = 1'b0;
    sdi = 1'b1;
    latch_n = 1'b1;
    for (int i = 0; i < NREGS; i++) model[i] = 8'h00;
    wt(10);
  endtask

  initial begin
    logic [7:0] rd;
    logic oe_all, oe_any;
    void'($urandom(32'd20240611));
    do_reset(1'b0);
    chk("R8 reset cfg", cfg_flat, 64'h0);
    chk("R8 standalone low", {63'h0, standalone}, 64'h0);
    chk("R8 sdo_oe low", {63'h0, sdo_oe}, 64'h0);

    // directed: write then read
    xfer({8'h08, 8'h03, 8'hA5}, 24, rd, oe_all, oe_any);
    model[3] = 8'hA5;
    chk("R1 R3 write", cfg_flat, exp_cfg());
    xfer({8'h09, 8'h03, 8'h00}, 24, rd, oe_all, oe_any);
    chk("R5 read data", {56'h0, rd}, {56'h0, 8'hA5});
    chk("R5 oe during byte3", {63'h0, oe_all}, 64'h1);
    // short and long frames
    xfer({8'h08, 8'h02, 8'h5A}, 23, rd, oe_all, oe_any);
    chk("R4 23-bit frame", cfg_flat, exp_cfg());
    xfer({8'h08, 8'h02, 8'h5A}, 25, rd, oe_all, oe_any);
    chk("R4 25-bit frame", cfg_flat, exp_cfg());
    // wrong chip id
    xfer({8'h0A, 8'h02, 8'h5A}, 24, rd, oe_all, oe_any);
    chk("R2 foreign id write", cfg_flat, exp_cfg());
    xfer({8'h0B, 8'h03, 8'h00}, 24, rd, oe_all, oe_any);
    chk("R2 foreign id read oe", {63'h0, oe_any}, 64'h0);
    // unimplemented address
    xfer({8'h08, 8'h08, 8'hFF}, 24, rd, oe_all, oe_any);
    chk("R7 write high addr", cfg_flat, exp_cfg());
    xfer({8'h09, 8'h40, 8'h00}, 24, rd, oe_all, oe_any);
    chk("R7 read high addr", {55'h0, oe_all, rd}, {55'h0, 1'b1, 8'h00});

    // random traffic (R1 R2 R3 R4 R5 R7)
    for (int k = 0; k < 60; k++) begin
      logic [7:0] a, d;
      int kind;
      a = 8'($urandom_range(0, NREGS + 1));
      d = 8'($urandom);
      kind = $urandom_range(0, 9);
      case (kind)
        0: begin
          xfer({8'h0C, a, d}, 24, rd, oe_all, oe_any);
          chk("R2 random foreign", {oe_any, cfg_flat[62:0]}, {1'b0, exp_cfg()[62:0]});
        end
        1, 2: begin
          xfer({8'h08, a, d}, (kind == 1) ? 23 : 25, rd, oe_all, oe_any);
          chk("R4 random bad length", cfg_flat, exp_cfg());
        end
        3, 4, 5: begin
          xfer({8'h09, a, d}, 24, rd, oe_all, oe_any);
          chk("R5 R7 random read", {55'h0, oe_all, rd},
              {55'h0, 1'b1, (a < NREGS) ? model[a[2:0]] : 8'h00});
        end
        default: begin
          xfer({8'h08, a, d}, 24, rd, oe_all, oe_any);
          if (a < NREGS) model[a[2:0]] = d;
          chk("R3 R7 random write", cfg_flat, exp_cfg());
        end
      endcase
    end

    // fallback strap (R9 R10 R11)
    do_reset(1'b1);
    in_sa = 1;
    chk("R9 standalone high", {63'h0, standalone}, 64'h1);
    chk("R10 mclk forced", cfg_flat, 64'h1);
    xfer({8'h08, 8'h00, 8'h00}, 24, rd, oe_all, oe_any);
    xfer({8'h08, 8'h05, 8'h77}, 24, rd, oe_all, oe_any);
    chk("R9 writes ignored", cfg_flat, 64'h1);
    xfer({8'h09, 8'h00, 8'h00}, 24, rd, oe_all, oe_any);
    chk("R9 no read drive", {63'h0, oe_any}, 64'h0);
    in_sa = 0;

    do_reset(1'b0);
    chk("R8 reset clears fallback", {cfg_flat[62:0], standalone}, 64'h0);
    xfer({8'h08, 8'h07, 8'hC3}, 24, rd, oe_all, oe_any);
    model[7] = 8'hC3;
    chk("R11 write after fallback", cfg_flat, exp_cfg());

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule